// File: doc/BRIEF.md
# Phase-Frequency Detector with Minimum Overlap and Up-Pulse Limit

This block is a cycle-based digital model of a tri-state phase-frequency detector. It runs on a fast oversampling clock and watches two single-bit inputs: a reference and a feedback signal. Only their rising edges matter. The input whose edge comes first raises its output, either pump-up or pump-down. When the other edge arrives, both outputs are high together. They stay high for a programmable number of cycles and then clear as a pair. This forced overlap gives a downstream charge pump time to switch on before the phase difference is measured, so small phase errors do not fall into a dead zone.

An optional limiter protects a feedback divider from overshoot while the loop is locking. The block measures the reference period in oversampling clocks. When the limiter is on, it forces the pump-up output low once that output has been high for a quarter or an eighth of the measured period. The pump-down pulse is never shortened. Inverted copies of both outputs are provided with the same latency as the outputs they invert.

Top module: `pfd_limit`

## Requirements
- R1: A reference rising edge sampled at a clock edge, while no comparison is pending, sets `up` high after that same clock edge. `up` then stays high until the pair is cleared, unless the limiter cuts it.
- R2: A feedback rising edge sampled at a clock edge, while no comparison is pending, sets `dn` high after that same clock edge. `dn` then stays high until the pair is cleared.
- R3: Once both pulse states are high, they remain high together for exactly `ovl_cfg`+1 cycles and then fall in the same cycle. With a reference lead of d cycles, `up` is high for d+`ovl_cfg`+1 cycles and `dn` for `ovl_cfg`+1 cycles. A feedback lead gives the mirror result.
- R4: Reference and feedback edges that are sampled on the same clock edge produce two pulses, each `ovl_cfg`+1 cycles wide.
- R5: With `lim_en`=1 and a valid period P, `up` is high for at most P>>2 cycles when `lim_div8`=0, and at most P>>3 cycles when `lim_div8`=1. A shorter pulse is left unchanged.
- R6: P is the number of clock cycles between two consecutive reference rising edges. The limiter has no effect until two reference rising edges have been seen since reset.
- R7: The limiter never shortens `dn`. After a cut, `up` stays low until the feedback edge arrives and the normal overlap clear takes place. The next comparison then behaves normally.
- R8: `up_n` is always the inverse of `up`, and `dn_n` the inverse of `dn`, in the same cycle.
- R9: While `rst` is high at a clock edge, all state is cleared, including any pending pulse and the measured period. After that edge, `up`=0, `dn`=0, `up_n`=1 and `dn_n`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference clock level |
| fb_in | input | 1 | Feedback clock level |
| ovl_cfg | input | OVL_W | Extra overlap cycles added to the clear path |
| lim_en | input | 1 | Enables the up-pulse limiter |
| lim_div8 | input | 1 | Limit select: 0 gives period/4, 1 gives period/8 |
| up | output | 1 | Pump-up pulse |
| dn | output | 1 | Pump-down pulse |
| up_n | output | 1 | Inverse of up |
| dn_n | output | 1 | Inverse of dn |

## Verification
A stuck or lost pulse state shows at the ports within one comparison. The pulse widths then stop matching edge distance plus overlap, or one output never falls. A wrong overlap counter changes both widths by the same amount in the very next comparison. A wrong period measurement, or a wrong validity flag, shows up as a changed limited `up` width on the first comparison after two reference edges. It also shows as a cut that appears before any period has been measured, including right after a reset.

// File: rtl/pfd_limit.sv
module pfd_limit #(
  parameter int OVL_W = 4,
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [OVL_W-1:0] ovl_cfg,
  input  logic             lim_en,
  input  logic             lim_div8,
  output logic             up,
  output logic             dn,
  output logic             up_n,
  output logic             dn_n
);

  localparam logic [PER_W-1:0] PER_MAX = '1;

  logic             ref_q, fb_q;
  logic             up_st, dn_st;
  logic [OVL_W-1:0] ovl_cnt;
  logic [PER_W-1:0] per_cnt, per_len, up_cnt, lim_len;
  logic             ref_seen, per_ok, cut;

  wire ref_rise = ref_in & ~ref_q;
  wire fb_rise  = fb_in & ~fb_q;
  wire both     = up_st & dn_st;
  wire clear    = both && (ovl_cnt == ovl_cfg);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= 1'b0;
      fb_q    <= 1'b0;
      up_st   <= 1'b0;
      dn_st   <= 1'b0;
      ovl_cnt <= '0;
    end else begin
      ref_q <= ref_in;
      fb_q  <= fb_in;
      if (clear) begin
        up_st   <= 1'b0;
        dn_st   <= 1'b0;
        ovl_cnt <= '0;
      end else begin
        if (ref_rise) up_st <= 1'b1;
        if (fb_rise)  dn_st <= 1'b1;
        if (both)     ovl_cnt <= ovl_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_cnt  <= '0;
      per_len  <= '0;
      ref_seen <= 1'b0;
      per_ok   <= 1'b0;
    end else if (ref_rise) begin
      per_cnt  <= {{(PER_W-1){1'b0}}, 1'b1};
      ref_seen <= 1'b1;
      if (ref_seen) begin
        per_len <= per_cnt;
        per_ok  <= 1'b1;
      end
    end else if (per_cnt != PER_MAX) begin
      per_cnt <= per_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !up_st)         up_cnt <= '0;
    else if (up_cnt != PER_MAX) up_cnt <= up_cnt + 1'b1;
  end

  assign lim_len = lim_div8 ? (per_len >> 3) : (per_len >> 2);
  assign cut     = lim_en & per_ok & (up_cnt >= lim_len);

  assign up   = up_st & ~cut;
  assign dn   = dn_st;
  assign up_n = ~up;
  assign dn_n = ~dn;

  p_up_from_ref_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(up_st) |-> $past(ref_in && !ref_q));

  p_dn_from_fb_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_st) |-> $past(fb_in && !fb_q));

  p_pair_clear_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(dn_st) |-> ($fell(up_st) && $past(ovl_cnt == ovl_cfg)));

  p_cut_needs_limit_r5: assert property (@(posedge clk) disable iff (rst)
    (up_st && !up) |-> (lim_en && per_ok));

  p_dn_whole_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(dn) |-> $past(up_st));

endmodule

// File: tb/sim_pfd_limit.sv
`timescale 1ns/1ps
module sim_pfd_limit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, fb_in = 1'b0;
  logic [3:0] ovl_cfg = '0;
  logic lim_en = 1'b0, lim_div8 = 1'b0;
  logic up, dn, up_n, dn_n;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pfd_limit u0 (.clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .ovl_cfg(ovl_cfg), .lim_en(lim_en), .lim_div8(lim_div8),
    .up(up), .dn(dn), .up_n(up_n), .dn_n(dn_n));

  localparam int WIN = 64;
  localparam int REF_AT = 20;
  localparam int N = 11;
  // fb edge cycle, overlap cfg, limiter enable, div8, expected up / dn widths
  localparam int T_FB [N] = '{20, 25, 15, 30, 10, 20, 50, 50, 30,  5, 40};
  localparam int T_OV [N] = '{ 0,  0,  0,  3,  3,  5,  0,  0,  0,  2,  2};
  localparam int T_EN [N] = '{ 0,  0,  0,  0,  0,  0,  1,  1,  1,  1,  1};
  localparam int T_D8 [N] = '{ 0,  0,  0,  0,  0,  0,  0,  1,  0,  1,  1};
  localparam int T_UP [N] = '{ 1,  6,  1, 14,  4,  6, 16,  8, 11,  3,  8};
  localparam int T_DN [N] = '{ 1,  1,  6,  4, 14,  6,  1,  1,  1, 18,  3};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic window(int fb_at, string tag, int exp_up, int exp_dn);
    int nu = 0, nd = 0, bad = 0;
    for (int c = 0; c < WIN; c++) begin
      @(negedge clk);
      nu += int'(up);
      nd += int'(dn);
      if (up_n !== ~up || dn_n !== ~dn) bad++;
      ref_in = (c >= REF_AT) && (c < REF_AT + 2);
      fb_in  = (c >= fb_at) && (c < fb_at + 2);
    end
    check({tag, " up width"}, nu, exp_up);
    check({tag, " dn width"}, nd, exp_dn);
    check("R8 complement mismatches", bad, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset up", int'(up), 0);
    check("R9 reset dn", int'(dn), 0);
    check("R9 reset up_n", int'(up_n), 1);
    check("R9 reset dn_n", int'(dn_n), 1);
    rst = 1'b0;

    // R6: limiter inert before any period is known
    lim_en = 1'b1; lim_div8 = 1'b1;
    window(50, "R6 no period yet", 31, 1);

    for (int i = 0; i < N; i++) begin
      ovl_cfg  = 4'(T_OV[i]);
      lim_en   = T_EN[i][0];
      lim_div8 = T_D8[i][0];
      window(T_FB[i], $sformatf("R1/R2/R3/R4/R5/R7 row %0d", i), T_UP[i], T_DN[i]);
    end

    // R7: comparison after a cut behaves normally
    lim_en = 1'b0; ovl_cfg = 4'd1;
    window(27, "R7 after cut", 9, 2);

    // R9: reset in the middle of a pending up pulse
    lim_en = 1'b1; lim_div8 = 1'b0; ovl_cfg = 4'd0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      ref_in = (c >= REF_AT) && (c < REF_AT + 2);
    end
    @(negedge clk);
    check("R1 pending up before reset", int'(up), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 up cleared", int'(up), 0);
    check("R9 up_n after reset", int'(up_n), 1);
    repeat (10) @(negedge clk);
    check("R9 no pulse after reset", int'(up) + int'(dn), 0);
    // R6: the period was wiped, so no cut on the next comparison
    window(50, "R6 period cleared by reset", 31, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule